// File: doc/BRIEF.md
# Message Buffer Interrupt Flag Unit

This unit holds one pending flag for each of the sixteen message buffers of a CAN controller. It merges the flags into a single interrupt request towards the host. Buffer logic pulses a completion line when a buffer finishes a successful frame. The pulse means the same thing whether the frame was sent or received. Software chooses which buffers may interrupt through an enable mask. It acknowledges a flag by writing a one to that flag's bit position.

The request is driven onto the system bus as an encoded level. The level comes from a 3-bit priority field that software programs. A priority of zero keeps the request silent. The request and the level are registered, so they follow changes in the flags, the mask or the priority one clock later.

All register writes go through one plain write port. It has a strobe, a 2-bit target select and a 16-bit data word. There is no back-pressure, so every strobed write takes effect at the next clock edge. The flag, mask and priority registers are always visible on their output pins, and those pins serve as the read path.

Top module: `mb_irq_unit`

## Requirements
- R1: After reset, the flag, mask and priority registers are zero, and so are `irq_req` and `irq_level`.
- R2: A high bit on `done_pulse` sets the matching bit of `flag_q` at the next clock edge. The bit then stays set until software clears it.
- R3: A write with `wr_sel`=1 clears every `flag_q` bit whose `wr_data` bit is 1. Bits written with 0 keep their value.
- R4: When a completion pulse and a clear write hit the same bit in one cycle, the bit ends up set.
- R5: A write with `wr_sel`=0 loads `wr_data` into `mask_q`.
- R6: `irq_req` is high exactly one cycle after a cycle in which both of these hold: some bit is set in both `flag_q` and `mask_q`, and `prio_q` is nonzero.
- R7: While `prio_q` is 0, `irq_req` and `irq_level` stay 0 on the following cycle, whatever the flags and mask hold.
- R8: `irq_level` carries the priority that was programmed in the cycle before it, whenever `irq_req` is high. It is 0 whenever `irq_req` is low.
- R9: A write with `wr_sel`=3 changes no register.
- R10: A write with `wr_sel`=2 loads `wr_data[2:0]` into `prio_q`. The upper data bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_pulse | input | 16 | Per-buffer successful-completion pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mask, 1 flag clear, 2 priority, 3 none |
| wr_data | input | 16 | Write data |
| flag_q | output | 16 | Pending flags |
| mask_q | output | 16 | Interrupt enable mask |
| prio_q | output | 3 | Programmed priority |
| irq_req | output | 1 | Registered interrupt request |
| irq_level | output | 3 | Encoded bus level, 0 when idle |

## Verification
The case that is hardest to reach from the ports is a completion pulse and a clear write landing on the same bit in the same cycle, with the mask and priority already set so that the effect shows up on the request line. A directed sequence arranges exactly that collision. Long runs of sparse random pulses, random writes to every target and random priority values (including zero) then follow. A behavioural model predicts every output on every clock, so mask or priority changes that race a new flag are compared cycle by cycle.

// File: rtl/mbif_pkg.sv
package mbif_pkg;
  localparam int NBUF   = 16;
  localparam int PRIO_W = 3;
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_CLR  = 2'd1,
    SEL_PRIO = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;
endpackage

// File: rtl/mbif_flag_bank.sv
module mbif_flag_bank #(
  parameter int N = mbif_pkg::NBUF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)         flag_o[i] <= 1'b0;
      else if (set_i[i])  flag_o[i] <= 1'b1;
      else if (clr_i[i])  flag_o[i] <= 1'b0;
    end

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_o[i]);
    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[i] && !set_i[i]) |=> $stable(flag_o[i]));
  end
endmodule

// File: rtl/mbif_cfg_regs.sv
module mbif_cfg_regs #(
  parameter int N  = mbif_pkg::NBUF,
  parameter int PW = mbif_pkg::PRIO_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [N-1:0]  wr_data,
  output logic [N-1:0]  mask_o,
  output logic [PW-1:0] prio_o,
  output logic [N-1:0]  clr_o
);
  import mbif_pkg::*;
  logic wr_mask, wr_prio;

  always_comb begin
    wr_mask = wr_en && (wsel_e'(wr_sel) == SEL_MASK);
    wr_prio = wr_en && (wsel_e'(wr_sel) == SEL_PRIO);
    clr_o   = (wr_en && (wsel_e'(wr_sel) == SEL_CLR)) ? wr_data : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_o <= '0;
      prio_o <= '0;
    end else begin
      if (wr_mask) mask_o <= wr_data;
      if (wr_prio) prio_o <= wr_data[PW-1:0];
    end
  end

  p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> mask_o == $past(wr_data));
  p_prio_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2) |=> prio_o == $past(wr_data[PW-1:0]));
  p_none_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3) |=> ($stable(mask_o) && $stable(prio_o)));
endmodule

// File: rtl/mbif_level_enc.sv
module mbif_level_enc #(
  parameter int N  = mbif_pkg::NBUF,
  parameter int PW = mbif_pkg::PRIO_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  flag_i,
  input  logic [N-1:0]  mask_i,
  input  logic [PW-1:0] prio_i,
  output logic          req_o,
  output logic [PW-1:0] level_o
);
  logic pend;
  assign pend = (|(flag_i & mask_i)) && (prio_i != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_o   <= 1'b0;
      level_o <= '0;
    end else begin
      req_o   <= pend;
      level_o <= pend ? prio_i : '0;
    end
  end

  p_off_when_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_i == '0) |=> (!req_o && level_o == '0));
  p_level_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> level_o == $past(prio_i));
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_o |-> level_o == '0);
  p_req_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_i & mask_i) == '0) |=> !req_o);
endmodule

// File: rtl/mb_irq_unit.sv
module mb_irq_unit #(
  parameter int N  = mbif_pkg::NBUF,
  parameter int PW = mbif_pkg::PRIO_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  done_pulse,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [N-1:0]  wr_data,
  output logic [N-1:0]  flag_q,
  output logic [N-1:0]  mask_q,
  output logic [PW-1:0] prio_q,
  output logic          irq_req,
  output logic [PW-1:0] irq_level
);
  logic [N-1:0] clr;

  mbif_cfg_regs #(.N(N), .PW(PW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .mask_o(mask_q), .prio_o(prio_q), .clr_o(clr)
  );

  mbif_flag_bank #(.N(N)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(done_pulse), .clr_i(clr), .flag_o(flag_q)
  );

  mbif_level_enc #(.N(N), .PW(PW)) u_enc (
    .clk(clk), .rst_n(rst_n), .flag_i(flag_q), .mask_i(mask_q),
    .prio_i(prio_q), .req_o(irq_req), .level_o(irq_level)
  );

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (flag_q == '0 && mask_q == '0 && prio_q == '0 && !irq_req));
endmodule

// File: tb/mb_irq_unit_test.sv
module mb_irq_unit_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] done_pulse = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd3;
  logic [15:0] wr_data = '0;
  logic [15:0] flag_q, mask_q;
  logic [2:0]  prio_q, irq_level;
  logic        irq_req;

  int vectors = 0;
  int errors  = 0;
  bit done_flag = 0;

  int m_flag, m_mask, m_prio, m_req, m_lvl;

  always #(PERIOD/2) clk = ~clk;

  mb_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .done_pulse(done_pulse), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .flag_q(flag_q), .mask_q(mask_q),
    .prio_q(prio_q), .irq_req(irq_req), .irq_level(irq_level)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 flag_q", flag_q, m_flag);
    chk("R5 mask_q", mask_q, m_mask);
    chk("R10 prio_q", prio_q, m_prio);
    chk("R6 irq_req", irq_req, m_req);
    chk("R8 irq_level", irq_level, m_lvl);
  endtask

  // model advance: next state from current model state and driven inputs
  task automatic model_step();
    int nf, nm, np, pend;
    pend = ((m_flag & m_mask) != 0) && (m_prio != 0);
    nf = m_flag;
    nm = m_mask;
    np = m_prio;
    if (wr_en && wr_sel == 2'd1) nf = nf & ~int'(wr_data);
    nf = nf | int'(done_pulse);
    if (wr_en && wr_sel == 2'd0) nm = int'(wr_data);
    if (wr_en && wr_sel == 2'd2) np = int'(wr_data) % 8;
    m_req  = pend;
    m_lvl  = pend ? m_prio : 0;
    m_flag = nf;
    m_mask = nm;
    m_prio = np;
  endtask

  // one cycle: compare, drive, advance model
  task automatic cyc(input logic [15:0] dp, input logic we, input logic [1:0] ws,
                     input logic [15:0] wd);
    @(negedge clk);
    compare_all();
    done_pulse = dp; wr_en = we; wr_sel = ws; wr_data = wd;
    model_step();
  endtask

  task automatic idle(); cyc('0, 1'b0, 2'd3, '0); endtask

  initial begin
    m_flag = 0; m_mask = 0; m_prio = 0; m_req = 0; m_lvl = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 flag", flag_q, 0);
    chk("R1 mask", mask_q, 0);
    chk("R1 prio", prio_q, 0);
    chk("R1 req", irq_req, 0);
    chk("R1 level", irq_level, 0);
    rst_n = 1'b1;

    // R7: flag and mask set, priority zero -> silent
    cyc(16'h0010, 1'b1, 2'd0, 16'h00F0);
    idle(); idle();
    @(negedge clk);
    chk("R7 req off", irq_req, 0);
    chk("R7 level off", irq_level, 0);
    model_step();
    // R10 upper bits ignored
    cyc('0, 1'b1, 2'd2, 16'hFFF5);
    idle();
    @(negedge clk);
    chk("R10 prio", prio_q, 5);
    chk("R6 req on", irq_req, 1);
    chk("R8 level", irq_level, 5);
    model_step();
    // R9 select 3 has no effect
    cyc('0, 1'b1, 2'd3, 16'hFFFF);
    idle();
    @(negedge clk);
    chk("R9 mask", mask_q, 16'h00F0);
    chk("R9 prio", prio_q, 5);
    chk("R9 flag", flag_q, 16'h0010);
    model_step();
    // R3 clear with zeros keeps, with one clears
    cyc(16'h0021, 1'b0, 2'd3, '0);
    cyc('0, 1'b1, 2'd1, 16'h0011);
    @(negedge clk);
    chk("R3 w1c", flag_q, 16'h0020);
    model_step();
    // R4 collision: set wins
    cyc(16'h0020, 1'b1, 2'd1, 16'h0020);
    @(negedge clk);
    chk("R4 set wins", flag_q, 16'h0020);
    model_step();
    idle();
    @(negedge clk);
    chk("R4 req held", irq_req, 1);
    model_step();

    // random phase
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] dp;
      logic [1:0]  ws;
      dp = ($urandom % 4 == 0) ? 16'(1 << ($urandom % 16)) : 16'h0;
      ws = 2'($urandom);
      cyc(dp, ($urandom % 3 == 0), ws, 16'($urandom));
    end
    idle();
    @(negedge clk);
    compare_all();
    if (!done_flag) begin
      done_flag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done_flag) begin
      done_flag = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule